// File: doc/BRIEF.md
# Standby Supply Recharge Timer

This block decides when a retained supply rail has to be topped up while the chip is in standby. It advances only on cycles where a slow tick enable (a 32 kHz rate derived from the system clock) is high. At each tick it decides whether a recharge should begin. It sends that decision out as a single-cycle request. At every recharge it records a sample of a supply-good comparator.

Four modes are available. The first never recharges. The second recharges after a fixed number of ticks. The third adapts the interval to the comparator result seen at each recharge. The fourth recharges whenever the comparator reports the rail as low. Intervals are coded as a small mantissa and a power-of-two exponent. The block keeps two statistics: a short history of supply samples, and the longest gap between recharges after which the rail was still good. Software clears the gap statistic by writing the status register.

Top module: `recharge_timer`

## Requirements
- R1: A synchronous reset clears the sample history, the longest-gap value and the request output, and sets the adaptive interval to 1 tick.
- R2: Mode code 0 disables recharge: `recharge` never rises, whatever the other inputs do.
- R3: Mode code 1 is a fixed timer. The interval is P = (`per_man` + 1) << `per_exp` ticks. A recharge is decided on the tick where the ticks counted since the last recharge, including the current tick, reach P or more.
- R4: Mode code 2 is the adaptive timer. It works like R3 but compares the count with an internal interval. While the mode is not 2, that interval follows P. At each recharge in mode 2 the interval changes by 1 << `per_exp`. It grows when `supply_ok` is 1 and is capped at (`max_man` + 1) << `max_exp`. It shrinks when `supply_ok` is 0 and never goes below 1.
- R5: Mode code 3 is comparator-driven: a recharge is decided on every tick where `supply_ok` is 0.
- R6: `recharge` is registered. It is high for exactly the one clock cycle after the tick cycle on which the recharge was decided.
- R7: On every recharge, `sample_hist` shifts left by one and bit 0 takes `supply_ok` from the deciding tick. A value of 1 means the supply was good.
- R8: When a recharge happens with `supply_ok` = 1, and the gap in ticks since the previous recharge is larger than `max_gap`, then `max_gap` takes that gap. The gap includes the deciding tick. The tick counter and the recorded value both saturate at 65535.
- R9: A cycle with `stat_wr` high clears `max_gap` to 0 on the next edge. This takes priority over a recharge update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Slow-rate enable, one cycle per 32 kHz period |
| mode | input | 2 | 0 off, 1 fixed, 2 adaptive, 3 comparator |
| per_man | input | 5 | Interval mantissa |
| per_exp | input | 3 | Interval exponent |
| max_man | input | 5 | Adaptive ceiling mantissa |
| max_exp | input | 3 | Adaptive ceiling exponent |
| supply_ok | input | 1 | Comparator: rail above threshold |
| stat_wr | input | 1 | Status register write strobe |
| recharge | output | 1 | One-cycle recharge request |
| sample_hist | output | 4 | Last four supply samples, newest in bit 0 |
| max_gap | output | 16 | Longest good gap between recharges, in ticks |

## Verification
Most internal state is visible only through the timing of `recharge`. A wrong tick count or a wrong adaptive interval moves a request by one or more ticks. It therefore shows up at the next recharge, a few ticks after the error occurs. A wrong history shift or a wrong gap value appears at `sample_hist` or `max_gap` in the cycle right after the recharge. Saturation errors only appear after a gap of more than 65535 ticks, so that case is run on its own.

// File: rtl/recharge_timer.sv
module recharge_timer #(
  parameter int CNT_W = 16,
  parameter int MAN_W = 5,
  parameter int EXP_W = 3,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [MAN_W-1:0]  per_man,
  input  logic [EXP_W-1:0]  per_exp,
  input  logic [MAN_W-1:0]  max_man,
  input  logic [EXP_W-1:0]  max_exp,
  input  logic              supply_ok,
  input  logic              stat_wr,
  output logic              recharge,
  output logic [HIST_W-1:0] sample_hist,
  output logic [CNT_W-1:0]  max_gap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cur_q;
  logic [CNT_W:0]   elapsed, grown;
  logic [CNT_W-1:0] per_fix, per_top, step, gap_sat;
  logic             fire;

  assign per_fix = (CNT_W'(per_man) + ONE) << per_exp;
  assign per_top = (CNT_W'(max_man) + ONE) << max_exp;
  assign step    = ONE << per_exp;
  assign elapsed = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign grown   = {1'b0, cur_q} + {1'b0, step};
  assign gap_sat = elapsed[CNT_W] ? TOP : elapsed[CNT_W-1:0];

  always_comb begin
    fire = 1'b0;
    if (tick) begin
      case (mode)
        2'd1:    fire = elapsed >= {1'b0, per_fix};
        2'd2:    fire = elapsed >= {1'b0, cur_q};
        2'd3:    fire = !supply_ok;
        default: fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      cur_q       <= ONE;
      sample_hist <= '0;
      max_gap     <= '0;
      recharge    <= 1'b0;
    end else begin
      recharge <= fire;
      if (tick)
        cnt_q <= fire ? '0 : (cnt_q == TOP ? cnt_q : cnt_q + ONE);
      if (fire)
        sample_hist <= {sample_hist[HIST_W-2:0], supply_ok};
      if (stat_wr)
        max_gap <= '0;
      else if (fire && supply_ok && elapsed > {1'b0, max_gap})
        max_gap <= gap_sat;
      if (mode != 2'd2)
        cur_q <= per_fix;
      else if (fire) begin
        if (supply_ok)
          cur_q <= (grown > {1'b0, per_top}) ? per_top : grown[CNT_W-1:0];
        else
          cur_q <= (cur_q > step) ? cur_q - step : ONE;
      end
    end
  end
endmodule

// File: rtl/recharge_timer_chk.sv
module recharge_timer_chk #(
  parameter int CNT_W = 16,
  parameter int MAN_W = 5,
  parameter int EXP_W = 3,
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [1:0]        mode,
  input logic [MAN_W-1:0]  per_man,
  input logic [EXP_W-1:0]  per_exp,
  input logic [MAN_W-1:0]  max_man,
  input logic [EXP_W-1:0]  max_exp,
  input logic              supply_ok,
  input logic              stat_wr,
  input logic              recharge,
  input logic [HIST_W-1:0] sample_hist,
  input logic [CNT_W-1:0]  max_gap
);
  assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == 2'd0) |=> !recharge);

  assert_cmp_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == 2'd3) |=> (recharge == $past(!supply_ok)));

  assert_pulse_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    recharge |-> $past(tick));

  assert_hist_shift_R7: assert property (@(posedge clk) disable iff (rst)
    recharge |-> (sample_hist[HIST_W-1:1] == $past(sample_hist[HIST_W-2:0]) &&
                  sample_hist[0] == $past(supply_ok)));

  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!recharge && !$past(rst)) |-> $stable(sample_hist));

  assert_clear_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    $past(stat_wr) |-> (max_gap == '0));
endmodule

bind recharge_timer recharge_timer_chk #(
  .CNT_W(CNT_W), .MAN_W(MAN_W), .EXP_W(EXP_W), .HIST_W(HIST_W)
) u_chk (.*);

// File: tb/recharge_timer_bench.sv
module recharge_timer_bench;
  logic clk = 0, rst = 1, tick = 0, supply_ok = 1, stat_wr = 0;
  logic [1:0] mode = 0;
  logic [4:0] per_man = 0, max_man = 0;
  logic [2:0] per_exp = 0, max_exp = 0;
  logic recharge;
  logic [3:0] sample_hist;
  logic [15:0] max_gap;

  recharge_timer u_recharge_timer (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int m_cnt = 0, m_cur = 1, m_hist = 0, m_max = 0, m_rch = 0, m_prev = 0, m_rst = 1, m_wr = 0;
  logic [7:0] lfsr = 8'h5a;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cur = 1; m_hist = 0; m_max = 0; m_rch = 0; m_prev = 0; m_rst = 1; m_wr = 0;
    end else begin
      int p, mp, st, el, f;
      p = (int'(per_man) + 1) << per_exp;
      mp = (int'(max_man) + 1) << max_exp;
      st = 1 << per_exp;
      el = m_cnt + 1;
      f = 0;
      if (tick)
        case (mode)
          2'd1: f = (el >= p) ? 1 : 0;
          2'd2: f = (el >= m_cur) ? 1 : 0;
          2'd3: f = supply_ok ? 0 : 1;
          default: f = 0;
        endcase
      if (f != 0) begin
        m_hist = ((m_hist << 1) | int'(supply_ok)) & 15;
        if (supply_ok && el > m_max) m_max = (el > 65535) ? 65535 : el;
      end
      m_wr = stat_wr ? 1 : 0;
      if (stat_wr) m_max = 0;
      if (mode != 2'd2) m_cur = p;
      else if (f != 0) begin
        if (supply_ok) m_cur = (m_cur + st > mp) ? mp : m_cur + st;
        else m_cur = (m_cur > st) ? m_cur - st : 1;
      end
      if (tick) m_cnt = (f != 0) ? 0 : ((m_cnt < 65535) ? m_cnt + 1 : m_cnt);
      m_prev = m_rch;
      m_rch = f;
      m_rst = 0;
    end
  end

  function automatic string mode_tag();
    case (mode)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(recharge) != m_rch) begin
      fails++;
      $display("FAIL %s/R6 recharge: actual %0d expected %0d", m_rst ? "R1" : mode_tag(), recharge, m_rch);
    end
    if (m_prev != 0) begin
      checks++;
      if (int'(recharge) != m_rch) begin
        fails++;
        $display("FAIL R6 pulse width: actual %0d expected %0d", recharge, m_rch);
      end
    end
    checks++;
    if (int'(sample_hist) != m_hist) begin
      fails++;
      $display("FAIL %s history: actual %0h expected %0h", m_rst ? "R1" : "R7", sample_hist, m_hist);
    end
    checks++;
    if (int'(max_gap) != m_max) begin
      fails++;
      $display("FAIL %s max gap: actual %0d expected %0d", m_rst ? "R1" : (m_wr != 0 ? "R9" : "R8"), max_gap, m_max);
    end
  end

  task automatic run(int n, int gap, int okm, int wr_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick = 1;
      supply_ok = (okm == 0) ? 1'b1 : (okm == 1) ? 1'b0 : lfsr[0];
      stat_wr = (wr_every > 0 && i % wr_every == wr_every - 1);
      @(negedge clk);
      tick = 0;
      stat_wr = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R3: fixed interval of 6 ticks, rail good, occasional R9 clears
    mode = 2'd1; per_man = 5'd2; per_exp = 3'd1;
    run(40, 1, 0, 13);
    per_man = 5'd0; per_exp = 3'd0;
    run(20, 1, 2, 0);
    // R4: adaptive with ceiling 16, step 2
    mode = 2'd2; per_man = 5'd1; per_exp = 3'd1; max_man = 5'd3; max_exp = 3'd2;
    run(200, 0, 2, 0);
    run(80, 0, 0, 0);
    run(30, 0, 1, 0);
    run(60, 0, 2, 17);
    // R5: comparator mode
    mode = 2'd3;
    run(100, 0, 2, 9);
    // R2 then R8 saturation: long idle gap
    mode = 2'd0;
    run(66000, 0, 2, 0);
    mode = 2'd1; per_man = 5'd2; per_exp = 3'd1;
    run(30, 0, 0, 0);
    // R1: reset mid-run
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    run(12, 0, 0, 5);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cycles > 190000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
    finish_run();
  end
endmodule